// File: doc/BRIEF.md
# SDRAM Bank Timing Tracker

This block follows the row state of every bank of a synchronous DRAM and rules on each proposed command before it goes out. A command code, a bank address and the auto-precharge/all-banks address bit are presented together with a valid strobe. In the same cycle the block answers with a legal or illegal flag. When the command is legal and valid, the block updates its per-bank bookkeeping at the next clock edge. It also reports, per bank, whether a row is open, whether the bank is fully idle, and whether an open row is nearing or has reached its longest allowed open time.

All timing limits are parameters in clock cycles. Each one is the device time specification divided by the clock period and rounded up. A memory controller uses the flag to gate its command scheduler and uses the warnings to force a precharge before a row has been open too long.

Top module: `sdram_bank_tracker`

## Requirements
- R1: Command codes on `cmd_code` are 0 no-op, 1 activate, 2 read, 3 write, 4 precharge, 5 mode-register set, 6 refresh, 7 low-power entry (self refresh or power-down); bank i maps to bit i of every per-bank output. After reset every bank is idle, no row is open, no warning is raised, and every timing window counts as already satisfied.
- R2: An activate is legal only to a bank that is idle; once accepted, that bank's `bank_open` bit is set from the next cycle on.
- R3: A read or write is legal only to a bank with an open row, and only once at least TRCD cycles have elapsed since that bank's activate (the activate cycle counts as 0).
- R4: An activate to any bank is legal only once at least TRRD cycles have elapsed since the previous accepted activate.
- R5: A precharge with `cmd_a10` low is legal only to a bank with an open row whose activate lies at least TRAS_MIN cycles back; it closes that row.
- R6: A precharge with `cmd_a10` high is legal only when every open bank has met TRAS_MIN; it closes all open rows and leaves idle banks untouched.
- R7: A precharged bank reports idle, and accepts an activate, only once TRP cycles have elapsed since the precharge.
- R8: Mode-register set, refresh and low-power entry are legal only when every bank is idle; a bank still inside its TRP window is not idle.
- R9: An open bank raises `tras_warn` once TRAS_MAX-WARN_MARGIN cycles have elapsed since its activate and `tras_expired` once TRAS_MAX cycles have elapsed. Both stay high without wrapping until the row is closed, and both drop in the cycle after the precharge.
- R10: A valid command that breaks a rule raises `cmd_illegal` and changes no bank state.
- R11: A valid no-op is always legal; with `cmd_valid` low neither `cmd_legal` nor `cmd_illegal` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_code | input | 3 | Command code (see R1) |
| cmd_bank | input | BANK_BITS | Target bank |
| cmd_a10 | input | 1 | All-banks selector for precharge |
| cmd_legal | output | 1 | Presented command satisfies all rules |
| cmd_illegal | output | 1 | Presented command breaks a rule |
| bank_open | output | 2**BANK_BITS | Row open, per bank |
| bank_idle | output | 2**BANK_BITS | Closed and past TRP, per bank |
| tras_warn | output | 2**BANK_BITS | Row open time near its maximum |
| tras_expired | output | 2**BANK_BITS | Row open time at its maximum |

## Verification
Read and write probes are placed one cycle before and exactly at the TRCD edge. This separates an off-by-one in the activate-to-access count from a correct one. Pairs of activates spaced one cycle and TRRD cycles apart, and single-bank precharges tried one cycle early and then on time, do the same for TRRD and TRAS_MIN. A precharge-all with one bank still too young separates an all-bank check from a check of the addressed bank only. Global commands issued while a bank is open and while a bank is still precharging show whether the TRP window is counted as busy. Long holds past TRAS_MAX show whether the row-open counter saturates or wraps.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

   typedef enum logic [2:0] {
      CMD_NOP = 3'd0,
      CMD_ACT = 3'd1,
      CMD_RD  = 3'd2,
      CMD_WR  = 3'd3,
      CMD_PRE = 3'd4,
      CMD_MRS = 3'd5,
      CMD_REF = 3'd6,
      CMD_LPE = 3'd7
   } cmd_e;

   // commands that need the whole device quiet
   function automatic logic needs_all_idle(input cmd_e c);
      return (c == CMD_MRS) || (c == CMD_REF) || (c == CMD_LPE);
   endfunction

endpackage

// File: rtl/trk_sat_counter.sv
module trk_sat_counter #(
   parameter int unsigned LIMIT = 4,
   localparam int unsigned W = $clog2(LIMIT + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         restart,
   output logic [W-1:0] count,
   output logic         at_limit
);

   if (LIMIT < 1) begin : g_bad_limit
      $error("trk_sat_counter: LIMIT must be at least 1");
   end

   // reset preloads the limit so the window reads as already elapsed
   always_ff @(posedge clk) begin
      if (!rst_n)
         count <= W'(LIMIT);
      else if (restart)
         count <= W'(1);
      else if (count != W'(LIMIT))
         count <= count + 1'b1;
   end

   assign at_limit = (count == W'(LIMIT));

   p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      count <= W'(LIMIT));

endmodule

// File: rtl/trk_bank_state.sv
module trk_bank_state #(
   parameter int unsigned TRCD        = 3,
   parameter int unsigned TRAS_MIN    = 7,
   parameter int unsigned TRAS_MAX    = 7000,
   parameter int unsigned TRP         = 3,
   parameter int unsigned WARN_MARGIN = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic do_act,
   input  logic do_pre,
   output logic row_open,
   output logic ready_idle,
   output logic rcd_met,
   output logic ras_met,
   output logic warn,
   output logic expired
);

   localparam int unsigned AW = $clog2(TRAS_MAX + 1);
   localparam int unsigned PW = $clog2(TRP + 1);

   logic          open_q;
   logic [AW-1:0] act_cnt;
   logic          act_done;
   logic [PW-1:0] rp_cnt;
   logic          rp_done;

   always_ff @(posedge clk) begin
      if (!rst_n)
         open_q <= 1'b0;
      else if (do_act)
         open_q <= 1'b1;
      else if (do_pre)
         open_q <= 1'b0;
   end

   trk_sat_counter #(.LIMIT(TRAS_MAX)) i_act_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (do_act),
      .count    (act_cnt),
      .at_limit (act_done)
   );

   trk_sat_counter #(.LIMIT(TRP)) i_rp_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (do_pre),
      .count    (rp_cnt),
      .at_limit (rp_done)
   );

   assign row_open   = open_q;
   assign ready_idle = !open_q && rp_done;
   assign rcd_met    = open_q && (act_cnt >= AW'(TRCD));
   assign ras_met    = open_q && (act_cnt >= AW'(TRAS_MIN));
   assign expired    = open_q && act_done;

   if (WARN_MARGIN == 0) begin : g_warn_at_max
      assign warn = expired;
   end else begin : g_warn_early
      assign warn = open_q && (act_cnt >= AW'(TRAS_MAX - WARN_MARGIN));
   end

   p_act_from_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      do_act |-> ready_idle);

   p_act_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
      do_act |=> (row_open && !warn));

   p_pre_after_ras_r5: assert property (@(posedge clk) disable iff (!rst_n)
      do_pre |-> ras_met);

   p_pre_closes_r6: assert property (@(posedge clk) disable iff (!rst_n)
      do_pre |=> (!row_open && !expired));

   if (TRP > 1) begin : g_rp_check
      p_rp_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
         do_pre |=> !ready_idle);
   end

endmodule

// File: rtl/trk_cmd_judge.sv
module trk_cmd_judge
   import sdram_trk_pkg::*;
#(
   parameter int unsigned BANK_BITS = 2,
   localparam int unsigned NB = 1 << BANK_BITS
) (
   input  logic                 cmd_valid,
   input  cmd_e                 cmd,
   input  logic [BANK_BITS-1:0] bank,
   input  logic                 a10,
   input  logic                 rrd_met,
   input  logic [NB-1:0]        open_v,
   input  logic [NB-1:0]        idle_v,
   input  logic [NB-1:0]        rcd_v,
   input  logic [NB-1:0]        ras_v,
   output logic                 cmd_ok,
   output logic [NB-1:0]        do_act,
   output logic [NB-1:0]        do_pre
);

   logic [NB-1:0] sel;
   logic          take;

   always_comb begin
      sel       = '0;
      sel[bank] = 1'b1;
      unique case (cmd)
         CMD_NOP:        cmd_ok = 1'b1;
         CMD_ACT:        cmd_ok = idle_v[bank] && rrd_met;
         CMD_RD, CMD_WR: cmd_ok = rcd_v[bank];
         CMD_PRE:        cmd_ok = a10 ? (&(~open_v | ras_v)) : ras_v[bank];
         default:        cmd_ok = &idle_v;
      endcase
   end

   assign take   = cmd_valid && cmd_ok;
   assign do_act = (take && cmd == CMD_ACT) ? sel : '0;
   assign do_pre = (take && cmd == CMD_PRE) ? (a10 ? open_v : sel) : '0;

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
   import sdram_trk_pkg::*;
#(
   parameter int unsigned BANK_BITS   = 2,
   parameter int unsigned TRCD        = 3,
   parameter int unsigned TRRD        = 2,
   parameter int unsigned TRAS_MIN    = 7,
   parameter int unsigned TRAS_MAX    = 7000,
   parameter int unsigned TRP         = 3,
   parameter int unsigned WARN_MARGIN = 64,
   localparam int unsigned NB = 1 << BANK_BITS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_valid,
   input  logic [2:0]           cmd_code,
   input  logic [BANK_BITS-1:0] cmd_bank,
   input  logic                 cmd_a10,
   output logic                 cmd_legal,
   output logic                 cmd_illegal,
   output logic [NB-1:0]        bank_open,
   output logic [NB-1:0]        bank_idle,
   output logic [NB-1:0]        tras_warn,
   output logic [NB-1:0]        tras_expired
);

   localparam int unsigned RW = $clog2(TRRD + 1);

   if (TRCD < 1 || TRRD < 1 || TRP < 1) begin : g_bad_min
      $error("sdram_bank_tracker: TRCD, TRRD and TRP must be at least 1");
   end
   if (TRAS_MIN < TRCD || TRAS_MAX <= TRAS_MIN) begin : g_bad_ras
      $error("sdram_bank_tracker: need TRCD <= TRAS_MIN < TRAS_MAX");
   end
   if (WARN_MARGIN >= TRAS_MAX) begin : g_bad_warn
      $error("sdram_bank_tracker: WARN_MARGIN must be below TRAS_MAX");
   end

   cmd_e          cmd;
   logic          cmd_ok;
   logic          rrd_met;
   logic [RW-1:0] rrd_cnt;
   logic [NB-1:0] do_act, do_pre, rcd_v, ras_v;

   assign cmd = cmd_e'(cmd_code);

   trk_sat_counter #(.LIMIT(TRRD)) i_rrd_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (|do_act),
      .count    (rrd_cnt),
      .at_limit (rrd_met)
   );

   trk_cmd_judge #(.BANK_BITS(BANK_BITS)) i_judge (
      .cmd_valid (cmd_valid),
      .cmd       (cmd),
      .bank      (cmd_bank),
      .a10       (cmd_a10),
      .rrd_met   (rrd_met),
      .open_v    (bank_open),
      .idle_v    (bank_idle),
      .rcd_v     (rcd_v),
      .ras_v     (ras_v),
      .cmd_ok    (cmd_ok),
      .do_act    (do_act),
      .do_pre    (do_pre)
   );

   for (genvar b = 0; b < NB; b++) begin : g_bank
      trk_bank_state #(
         .TRCD        (TRCD),
         .TRAS_MIN    (TRAS_MIN),
         .TRAS_MAX    (TRAS_MAX),
         .TRP         (TRP),
         .WARN_MARGIN (WARN_MARGIN)
      ) i_bank (
         .clk        (clk),
         .rst_n      (rst_n),
         .do_act     (do_act[b]),
         .do_pre     (do_pre[b]),
         .row_open   (bank_open[b]),
         .ready_idle (bank_idle[b]),
         .rcd_met    (rcd_v[b]),
         .ras_met    (ras_v[b]),
         .warn       (tras_warn[b]),
         .expired    (tras_expired[b])
      );
   end

   assign cmd_legal   = cmd_valid && cmd_ok;
   assign cmd_illegal = cmd_valid && !cmd_ok;

   p_rrd_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_legal && cmd == CMD_ACT) |-> (rrd_cnt == RW'(TRRD)));

   p_access_after_rcd_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_legal && (cmd == CMD_RD || cmd == CMD_WR)) |-> bank_open[cmd_bank]);

   p_global_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_legal && needs_all_idle(cmd)) |-> (&bank_idle && $countones(bank_open) == 0));

   p_illegal_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_illegal |=> $stable(bank_open));

endmodule

// File: tb/test_sdram_bank_tracker.sv
module test_sdram_bank_tracker;
   import sdram_trk_pkg::*;

   localparam int CLK_NS   = 20;
   localparam int TRCD     = 3;
   localparam int TRRD     = 2;
   localparam int TRAS_MIN = 6;
   localparam int TRAS_MAX = 30;
   localparam int TRP      = 3;
   localparam int WARN     = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [2:0] cmd_code = 3'd0;
   logic [1:0] cmd_bank = 2'd0;
   logic       cmd_a10 = 1'b0;
   logic       cmd_legal, cmd_illegal;
   logic [3:0] bank_open, bank_idle, tras_warn, tras_expired;

   int  total = 0;
   int  fails = 0;
   bit  done = 0;

   always #(CLK_NS / 2) clk = ~clk;

   sdram_bank_tracker #(
      .BANK_BITS(2), .TRCD(TRCD), .TRRD(TRRD), .TRAS_MIN(TRAS_MIN),
      .TRAS_MAX(TRAS_MAX), .TRP(TRP), .WARN_MARGIN(WARN)
   ) i_sdram_bank_tracker (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .cmd_bank(cmd_bank), .cmd_a10(cmd_a10), .cmd_legal(cmd_legal),
      .cmd_illegal(cmd_illegal), .bank_open(bank_open), .bank_idle(bank_idle),
      .tras_warn(tras_warn), .tras_expired(tras_expired)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
      end
   endtask

   // present a command for one cycle; sampled 1 ns after the falling edge
   task automatic drive(input logic v, input cmd_e c, input logic [1:0] b, input logic a);
      @(negedge clk);
      cmd_valid = v;
      cmd_code  = c;
      cmd_bank  = b;
      cmd_a10   = a;
      #1;
   endtask

   task automatic expect_cmd(input string tag, input logic exp);
      check({tag, " legal"}, cmd_legal, exp);
      check({tag, " illegal"}, cmd_illegal, !exp);
   endtask

   task automatic idle_cycles(input int n);
      for (int i = 0; i < n; i++) drive(1'b0, CMD_NOP, 2'd0, 1'b0);
   endtask

   task automatic close_all();
      idle_cycles(TRAS_MIN);
      drive(1'b1, CMD_PRE, 2'd0, 1'b1);
      expect_cmd("R6 precharge-all after TRAS_MIN", 1'b1);
      idle_cycles(TRP);
   endtask

   task automatic t_reset();
      drive(1'b0, CMD_NOP, 2'd0, 1'b0);
      check("R1 reset open", bank_open, 4'h0);
      check("R1 reset idle", bank_idle, 4'hF);
      check("R1 reset warn", tras_warn, 4'h0);
      check("R1 reset expired", tras_expired, 4'h0);
      drive(1'b1, CMD_MRS, 2'd0, 1'b0);
      expect_cmd("R1 mode-set right after reset", 1'b1);
   endtask

   task automatic t_act_rcd();
      drive(1'b1, CMD_ACT, 2'd1, 1'b0);
      expect_cmd("R1 first activate", 1'b1);
      drive(1'b1, CMD_RD, 2'd1, 1'b0);
      expect_cmd("R3 read at 1", 1'b0);
      check("R2 bank1 opened", bank_open, 4'b0010);
      drive(1'b1, CMD_WR, 2'd1, 1'b0);
      expect_cmd("R3 write at TRCD-1", 1'b0);
      drive(1'b1, CMD_RD, 2'd1, 1'b0);
      expect_cmd("R3 read at TRCD", 1'b1);
      drive(1'b1, CMD_WR, 2'd1, 1'b0);
      expect_cmd("R3 write after TRCD", 1'b1);
      drive(1'b1, CMD_ACT, 2'd1, 1'b0);
      expect_cmd("R2 activate to open bank", 1'b0);
      drive(1'b1, CMD_RD, 2'd2, 1'b0);
      expect_cmd("R3 read to closed bank", 1'b0);
      close_all();
   endtask

   task automatic t_rrd();
      drive(1'b1, CMD_ACT, 2'd0, 1'b0);
      expect_cmd("R4 activate bank0", 1'b1);
      drive(1'b1, CMD_ACT, 2'd1, 1'b0);
      expect_cmd("R4 activate 1 cycle later", 1'b0);
      drive(1'b1, CMD_ACT, 2'd1, 1'b0);
      expect_cmd("R4 activate TRRD later", 1'b1);
      drive(1'b1, CMD_ACT, 2'd2, 1'b0);
      expect_cmd("R4 third activate too soon", 1'b0);
      drive(1'b1, CMD_ACT, 2'd2, 1'b0);
      expect_cmd("R4 third activate on time", 1'b1);
      drive(1'b0, CMD_NOP, 2'd0, 1'b0);
      check("R4 three banks open", bank_open, 4'b0111);
      close_all();
   endtask

   task automatic t_pre_single();
      drive(1'b1, CMD_ACT, 2'd3, 1'b0);
      expect_cmd("R5 activate bank3", 1'b1);
      idle_cycles(TRAS_MIN - 2);
      drive(1'b1, CMD_PRE, 2'd3, 1'b0);
      expect_cmd("R5 precharge at TRAS_MIN-1", 1'b0);
      drive(1'b1, CMD_PRE, 2'd3, 1'b0);
      expect_cmd("R5 precharge at TRAS_MIN", 1'b1);
      drive(1'b1, CMD_ACT, 2'd3, 1'b0);
      expect_cmd("R7 activate 1 after precharge", 1'b0);
      check("R5 bank3 closed", bank_open, 4'h0);
      check("R7 bank3 busy", bank_idle, 4'b0111);
      drive(1'b1, CMD_PRE, 2'd0, 1'b0);
      expect_cmd("R5 precharge of idle bank", 1'b0);
      check("R7 bank3 idle at TRP-1", bank_idle[3], 1'b0);
      drive(1'b1, CMD_ACT, 2'd3, 1'b0);
      check("R7 bank3 idle at TRP", bank_idle[3], 1'b1);
      expect_cmd("R7 activate at TRP", 1'b1);
      close_all();
   endtask

   task automatic t_pre_all();
      drive(1'b1, CMD_ACT, 2'd0, 1'b0);
      expect_cmd("R6 activate bank0", 1'b1);
      idle_cycles(1);
      drive(1'b1, CMD_ACT, 2'd2, 1'b0);
      expect_cmd("R6 activate bank2", 1'b1);
      drive(1'b1, CMD_PRE, 2'd1, 1'b1);
      expect_cmd("R6 precharge-all with young bank2", 1'b0);
      idle_cycles(TRAS_MIN - 2);
      drive(1'b1, CMD_PRE, 2'd1, 1'b1);
      expect_cmd("R6 precharge-all once all old enough", 1'b1);
      drive(1'b0, CMD_NOP, 2'd0, 1'b0);
      check("R6 all rows closed", bank_open, 4'h0);
      check("R6 only precharged banks busy", bank_idle, 4'b1010);
      idle_cycles(TRP - 2);
      drive(1'b0, CMD_NOP, 2'd0, 1'b0);
      check("R7 all idle after TRP", bank_idle, 4'hF);
   endtask

   task automatic t_global();
      drive(1'b1, CMD_REF, 2'd0, 1'b0);
      expect_cmd("R8 refresh all idle", 1'b1);
      drive(1'b1, CMD_LPE, 2'd0, 1'b0);
      expect_cmd("R8 low-power all idle", 1'b1);
      drive(1'b1, CMD_ACT, 2'd1, 1'b0);
      expect_cmd("R8 activate bank1", 1'b1);
      drive(1'b1, CMD_MRS, 2'd0, 1'b0);
      expect_cmd("R8 mode-set with open bank", 1'b0);
      drive(1'b1, CMD_REF, 2'd0, 1'b0);
      expect_cmd("R8 refresh with open bank", 1'b0);
      idle_cycles(TRAS_MIN - 3);
      drive(1'b1, CMD_PRE, 2'd1, 1'b0);
      expect_cmd("R8 precharge bank1", 1'b1);
      drive(1'b1, CMD_REF, 2'd0, 1'b0);
      expect_cmd("R8 refresh during TRP", 1'b0);
      idle_cycles(TRP - 2);
      drive(1'b1, CMD_REF, 2'd0, 1'b0);
      expect_cmd("R8 refresh after TRP", 1'b1);
   endtask

   task automatic t_tras();
      drive(1'b1, CMD_ACT, 2'd2, 1'b0);
      expect_cmd("R9 activate bank2", 1'b1);
      idle_cycles(TRAS_MAX - WARN - 2);
      drive(1'b1, CMD_NOP, 2'd0, 1'b0);
      check("R9 no warn one early", tras_warn, 4'h0);
      drive(1'b1, CMD_NOP, 2'd0, 1'b0);
      check("R9 warn at MAX-MARGIN", tras_warn, 4'b0100);
      check("R9 not expired yet", tras_expired, 4'h0);
      idle_cycles(WARN - 2);
      drive(1'b0, CMD_NOP, 2'd0, 1'b0);
      check("R9 not expired at MAX-1", tras_expired, 4'h0);
      drive(1'b0, CMD_NOP, 2'd0, 1'b0);
      check("R9 expired at MAX", tras_expired, 4'b0100);
      idle_cycles(10);
      drive(1'b0, CMD_NOP, 2'd0, 1'b0);
      check("R9 expired held past MAX", tras_expired, 4'b0100);
      check("R9 warn held past MAX", tras_warn, 4'b0100);
      drive(1'b1, CMD_PRE, 2'd2, 1'b0);
      expect_cmd("R9 precharge expired row", 1'b1);
      drive(1'b0, CMD_NOP, 2'd0, 1'b0);
      check("R9 warn cleared", tras_warn, 4'h0);
      check("R9 expired cleared", tras_expired, 4'h0);
      idle_cycles(TRP);
   endtask

   task automatic t_illegal();
      drive(1'b1, CMD_RD, 2'd0, 1'b0);
      expect_cmd("R10 read to idle bank", 1'b0);
      drive(1'b1, CMD_PRE, 2'd1, 1'b0);
      expect_cmd("R10 precharge idle bank", 1'b0);
      check("R10 state after illegal read", bank_open, 4'h0);
      drive(1'b0, CMD_NOP, 2'd0, 1'b0);
      check("R10 idle kept after illegal precharge", bank_idle, 4'hF);
      drive(1'b1, CMD_ACT, 2'd0, 1'b0);
      expect_cmd("R10 activate bank0", 1'b1);
      drive(1'b1, CMD_ACT, 2'd3, 1'b0);
      expect_cmd("R10 activate too soon", 1'b0);
      drive(1'b0, CMD_NOP, 2'd0, 1'b0);
      check("R10 bank3 untouched", bank_open, 4'b0001);
      check("R10 bank3 still idle", bank_idle, 4'b1110);
      close_all();
   endtask

   task automatic t_nop();
      drive(1'b0, CMD_ACT, 2'd0, 1'b0);
      check("R11 no valid legal", cmd_legal, 1'b0);
      check("R11 no valid illegal", cmd_illegal, 1'b0);
      drive(1'b1, CMD_ACT, 2'd2, 1'b0);
      expect_cmd("R11 activate bank2", 1'b1);
      drive(1'b1, CMD_NOP, 2'd2, 1'b1);
      expect_cmd("R11 no-op with open row", 1'b1);
      close_all();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_act_rcd();
      t_rrd();
      t_pre_single();
      t_pre_all();
      t_global();
      t_tras();
      t_illegal();
      t_nop();
      done = 1;
      $display("  %0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      #(CLK_NS * 20000);
      if (!done) begin
         total++;
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  %0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

endmodule